// File: doc/BRIEF.md
# Accumulator processor with interrupt cycle

This block is a small multi-cycle processor built around a single accumulator. Each instruction goes through a fetch cycle, an execute cycle and a check for an interrupt. Instructions and data share one synchronous single-port memory with a one-cycle read latency. The processor drives the address, write data and write strobe from registers and takes the read word one cycle after the address it issued.

An instruction word is 16 bits. The opcode sits in bits [15:12] and a 12-bit memory address sits in bits [11:0]. A status word holds four result flags, an interrupt-enable bit and a supervisor bit. The interrupt-enable bit controls when the single request line is served. To serve a request, the processor saves the status word and the program counter on a stack in memory that grows downward. It then jumps to a handler whose address it reads from a small vector table, selected by a 2-bit type input. A return opcode unwinds the stack.

Top module: `acc_cpu`

## Requirements
- R1: Synchronous active-high reset sets the program counter to 0x100, the accumulator and every status bit to 0, and the stack pointer to 0xFFF. While reset is held, mem_we, irq_ack and halted are 0.
- R2: The fetch step reads the word at the program counter into the instruction register and then adds one to the program counter. The opcode is taken from bits [15:12] and the operand address from bits [11:0]. Instructions run in address order.
- R3: Opcode 0x1 loads the word at the operand address into the accumulator. Opcode 0x2 writes the accumulator to the operand address. Opcode 0x5 adds the word at the operand address to the accumulator, modulo 2^16.
- R4: After a load or an add, the zero, negative and positive flags describe the new accumulator value, and at most one of them is set. Only an interrupt entry or a return changes the flags in any other way.
- R5: An add sets the overflow flag on signed two's-complement overflow and clears it otherwise. A load clears the overflow flag.
- R6: Opcode 0x3 copies bit 0 of the word at the operand address into the interrupt-enable bit and leaves the flags unchanged. All opcodes that have no defined action (0x4, 0x6 to 0xE) change no state and write nothing.
- R7: After each instruction, if interrupt-enable is 1 and irq_req is 1, the processor enters the interrupt cycle:
  - irq_ack pulses for one cycle.
  - The status word is written at the stack pointer, then the address of the next instruction is written at the stack pointer minus one. The stack pointer drops by two.
  - Interrupt-enable is cleared and the supervisor bit is set.
  - Execution continues at the low 12 bits of the word stored at address irq_type.
- R8: irq_req has no effect while interrupt-enable is 0. A request that is still held when interrupt-enable becomes 1 again is served after the next instruction boundary. This includes a return that restores the enable bit.
- R9: Opcode 0xF returns from an interrupt. It reloads the program counter from stack pointer plus one, then reloads the status word (flags, supervisor and interrupt-enable bits) from stack pointer plus two. The stack pointer rises by two.
- R10: Opcode 0x0 halts the processor. halted goes to 1 and stays there until reset. No further fetches, memory writes or interrupt acknowledges occur.
- R11: The saved status word has interrupt-enable in bit 0, supervisor in bit 1, positive in bit 4, negative in bit 5, zero in bit 6 and overflow in bit 7. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Registered memory address |
| mem_wdata | output | 16 | Registered memory write data |
| mem_we | output | 1 | Registered memory write strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after the address is sampled |
| irq_req | input | 1 | Level interrupt request, held until acknowledged |
| irq_type | input | 2 | Selects the vector table entry |
| irq_ack | output | 1 | One-cycle acknowledge of an interrupt being taken |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Several properties are checked on every cycle:
- the program counter advances by one after each fetch;
- the acknowledge is a single-cycle pulse, lines up with the first stack write, occurs only while interrupts are enabled, and clears the enable bit;
- a halt is sticky and silent;
- flags move only on a load, an add, an interrupt entry or a return, and after an arithmetic update at most one sign flag is set.

The bench scenarios are the only way to show the stored values. They check accumulator sums and overflow cases through memory, and the exact status words and return addresses on the stack. They also show that a request is held off while interrupts are disabled and served after a return re-enables them, that a handler which re-enables interrupts causes a nested entry, and that flags are restored on return.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_SETIE = 4'h3;
  localparam logic [3:0] OP_ADD   = 4'h5;
  localparam logic [3:0] OP_RTI   = 4'hF;

  // bit positions of the saved status word
  localparam int PSW_IE  = 0;
  localparam int PSW_SUP = 1;
  localparam int PSW_P   = 4;
  localparam int PSW_N   = 5;
  localparam int PSW_Z   = 6;
  localparam int PSW_V   = 7;

  typedef struct packed {
    logic v;
    logic z;
    logic n;
    logic p;
  } flags_t;

  typedef enum logic [3:0] {
    S_FETCH, S_FWAIT, S_FLATCH, S_EXEC,
    S_MWAIT, S_MDATA, S_INTCHK, S_PUSHPC,
    S_VEC, S_VWAIT, S_VLOAD,
    S_RWAIT1, S_RPC, S_RWAIT2, S_RPSW, S_HALT
  } state_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              do_add,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output flags_t            flags
);

  logic [DATA_W-1:0] sum;

  always_comb begin
    sum     = acc + operand;
    result  = do_add ? sum : operand;
    flags.v = do_add && (acc[DATA_W-1] == operand[DATA_W-1])
                     && (sum[DATA_W-1] != acc[DATA_W-1]);
    flags.z = (result == '0);
    flags.n = result[DATA_W-1];
    flags.p = !flags.z && !result[DATA_W-1];
  end

endmodule

// File: rtl/acc_psw.sv
module acc_psw
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_we,
  input  flags_t            flags_in,
  input  logic              ie_we,
  input  logic              ie_in,
  input  logic              enter_int,
  input  logic              restore_we,
  input  logic              restore_ie,
  input  logic              restore_sup,
  input  flags_t            restore_flags,
  output logic              ie,
  output logic              sup,
  output flags_t            flags,
  output logic [DATA_W-1:0] word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ie    <= 1'b0;
      sup   <= 1'b0;
      flags <= '0;
    end else if (restore_we) begin
      ie    <= restore_ie;
      sup   <= restore_sup;
      flags <= restore_flags;
    end else if (enter_int) begin
      ie  <= 1'b0;
      sup <= 1'b1;
    end else begin
      if (ie_we)   ie    <= ie_in;
      if (flag_we) flags <= flags_in;
    end
  end

  always_comb begin
    word          = '0;
    word[PSW_IE]  = ie;
    word[PSW_SUP] = sup;
    word[PSW_P]   = flags.p;
    word[PSW_N]   = flags.n;
    word[PSW_Z]   = flags.z;
    word[PSW_V]   = flags.v;
  end

  // R4
  sign_flags_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> $onehot0({flags.p, flags.n, flags.z}));

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_we && !restore_we) |=> $stable(flags));

  // R7
  entry_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (enter_int && !restore_we) |=> (!ie && sup));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 12,
  parameter int RESET_PC = 'h100,
  parameter int VEC_BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              irq_req,
  input  logic [1:0]        irq_type,
  output logic              irq_ack,
  output logic              halted
);

  localparam int OP_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] STACK_TOP = {ADDR_W{1'b1}};
  localparam logic [OP_W-1:0] C_HALT  = OP_W'(OP_HALT);
  localparam logic [OP_W-1:0] C_LOAD  = OP_W'(OP_LOAD);
  localparam logic [OP_W-1:0] C_STORE = OP_W'(OP_STORE);
  localparam logic [OP_W-1:0] C_SETIE = OP_W'(OP_SETIE);
  localparam logic [OP_W-1:0] C_ADD   = OP_W'(OP_ADD);
  localparam logic [OP_W-1:0] C_RTI   = OP_W'(OP_RTI);

  state_t            state;
  logic [ADDR_W-1:0] pc, sp;
  logic [DATA_W-1:0] ir, acc;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] opnd_addr;

  logic              psw_ie, psw_sup;
  flags_t            psw_flags, alu_flags, rest_flags;
  logic [DATA_W-1:0] psw_word, alu_result;
  logic              is_arith, flag_we, ie_we, enter_int, restore_we;

  assign op        = ir[DATA_W-1:ADDR_W];
  assign opnd_addr = ir[ADDR_W-1:0];
  assign is_arith  = (op == C_LOAD) || (op == C_ADD);
  assign flag_we   = (state == S_MDATA) && is_arith;
  assign ie_we     = (state == S_MDATA) && (op == C_SETIE);
  assign enter_int = (state == S_PUSHPC);
  assign restore_we = (state == S_RPSW);
  assign rest_flags = '{v: mem_rdata[PSW_V], z: mem_rdata[PSW_Z],
                        n: mem_rdata[PSW_N], p: mem_rdata[PSW_P]};

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .do_add  (op == C_ADD),
    .acc     (acc),
    .operand (mem_rdata),
    .result  (alu_result),
    .flags   (alu_flags)
  );

  acc_psw #(.DATA_W(DATA_W)) u_psw (
    .clk           (clk),
    .rst           (rst),
    .flag_we       (flag_we),
    .flags_in      (alu_flags),
    .ie_we         (ie_we),
    .ie_in         (mem_rdata[0]),
    .enter_int     (enter_int),
    .restore_we    (restore_we),
    .restore_ie    (mem_rdata[PSW_IE]),
    .restore_sup   (mem_rdata[PSW_SUP]),
    .restore_flags (rest_flags),
    .ie            (psw_ie),
    .sup           (psw_sup),
    .flags         (psw_flags),
    .word          (psw_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_FETCH;
      pc        <= ADDR_W'(RESET_PC);
      sp        <= STACK_TOP;
      ir        <= '0;
      acc       <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      irq_ack   <= 1'b0;
      halted    <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      irq_ack <= 1'b0;
      case (state)
        S_FETCH: begin
          mem_addr <= pc;
          state    <= S_FWAIT;
        end
        S_FWAIT:  state <= S_FLATCH;
        S_FLATCH: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (op == C_HALT) begin
            halted <= 1'b1;
            state  <= S_HALT;
          end else if (is_arith || op == C_SETIE) begin
            mem_addr <= opnd_addr;
            state    <= S_MWAIT;
          end else if (op == C_STORE) begin
            mem_addr  <= opnd_addr;
            mem_wdata <= acc;
            mem_we    <= 1'b1;
            state     <= S_INTCHK;
          end else if (op == C_RTI) begin
            mem_addr <= sp + 1'b1;
            state    <= S_RWAIT1;
          end else begin
            state <= S_INTCHK;
          end
        end
        S_MWAIT: state <= S_MDATA;
        S_MDATA: begin
          if (is_arith) acc <= alu_result;
          state <= S_INTCHK;
        end
        S_INTCHK: begin
          if (psw_ie && irq_req) begin
            irq_ack   <= 1'b1;
            mem_addr  <= sp;
            mem_wdata <= psw_word;
            mem_we    <= 1'b1;
            sp        <= sp - 1'b1;
            state     <= S_PUSHPC;
          end else begin
            state <= S_FETCH;
          end
        end
        S_PUSHPC: begin
          mem_addr  <= sp;
          mem_wdata <= DATA_W'(pc);
          mem_we    <= 1'b1;
          sp        <= sp - 1'b1;
          state     <= S_VEC;
        end
        S_VEC: begin
          mem_addr <= ADDR_W'(VEC_BASE) + ADDR_W'(irq_type);
          state    <= S_VWAIT;
        end
        S_VWAIT: state <= S_VLOAD;
        S_VLOAD: begin
          pc    <= mem_rdata[ADDR_W-1:0];
          state <= S_FETCH;
        end
        S_RWAIT1: state <= S_RPC;
        S_RPC: begin
          pc       <= mem_rdata[ADDR_W-1:0];
          mem_addr <= sp + ADDR_W'(2);
          state    <= S_RWAIT2;
        end
        S_RWAIT2: state <= S_RPSW;
        S_RPSW: begin
          sp    <= sp + ADDR_W'(2);
          state <= S_INTCHK;
        end
        S_HALT:  state <= S_HALT;
        default: state <= S_FETCH;
      endcase
    end
  end

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_FLATCH) |=> (pc == $past(pc) + 1'b1));

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  // R7
  ack_push_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (mem_we && mem_wdata == psw_word && psw_ie));

  // R8
  ack_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(psw_ie));

  // R7
  ie_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (!psw_ie && psw_sup));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we && !irq_ack));

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic        irq_req = 1'b0;
  logic [1:0]  irq_type = 2'd0;
  logic        irq_ack;
  logic        halted;

  logic [15:0] mem [4096];
  logic        pl_en = 1'b0;
  logic [11:0] pl_addr = '0;
  logic [15:0] pl_data = '0;

  int n_chk = 0;
  int n_err = 0;
  int ack_cnt = 0;
  int halt_we = 0;

  always #5 clk = ~clk;

  acc_cpu uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .irq_req(irq_req),
    .irq_type(irq_type), .irq_ack(irq_ack), .halted(halted)
  );

  always @(posedge clk) begin
    if (pl_en) mem[pl_addr] <= pl_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    if (rst) begin
      ack_cnt <= 0;
      halt_we <= 0;
    end else begin
      if (irq_ack) ack_cnt <= ack_cnt + 1;
      if (halted && (mem_we || irq_ack)) halt_we <= halt_we + 1;
    end
  end

  // a + b, flags, interrupt-enable set by the program
  localparam logic [31:0] VEC [6] = '{
    32'h0003_0002, 32'h7FFF_0001, 32'hFFFF_0001,
    32'h8000_8000, 32'hFFFE_FFFF, 32'h1234_0000
  };

  function automatic logic [15:0] exp_psw(logic [15:0] a, logic [15:0] b);
    logic [15:0] s;
    logic v, z, n, p;
    s = a + b;
    v = (a[15] == b[15]) && (s[15] != a[15]);
    z = (s == 16'h0);
    n = s[15];
    p = !z && !n;
    return {8'h00, v, z, n, p, 2'b00, 1'b0, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    pl_addr = a;
    pl_data = d;
    pl_en   = 1'b1;
    @(negedge clk);
    pl_en   = 1'b0;
  endtask

  task automatic begin_test();
    @(negedge clk);
    rst = 1'b1;
    irq_req = 1'b0;
    poke(12'hFFF, 16'hDEAD);
    poke(12'hFFE, 16'hDEAD);
    poke(12'hFFD, 16'hDEAD);
    poke(12'hFFC, 16'hDEAD);
  endtask

  // mode 0: drop on first ack; 1: drop, re-raise 3 cycles later, drop on second; 2: drop on second
  task automatic run_prog(input int mode);
    int c;
    int gap;
    c = 0;
    gap = 0;
    @(negedge clk);
    rst = 1'b0;
    while (!halted && c < 3000) begin
      @(negedge clk);
      c++;
      if (mode == 0 && ack_cnt >= 1) irq_req = 1'b0;
      if (mode == 1) begin
        if (ack_cnt == 1) begin
          gap++;
          irq_req = (gap >= 3);
        end else if (ack_cnt >= 2) irq_req = 1'b0;
      end
      if (mode == 2 && ack_cnt >= 2) irq_req = 1'b0;
    end
    chk("R10 halt reached", {15'd0, halted}, 16'h0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // vector table: load, add, store, enable -> interrupt, handler halts
    for (int i = 0; i < 6; i++) begin
      logic [15:0] a, b;
      a = VEC[i][31:16];
      b = VEC[i][15:0];
      begin_test();
      poke(12'h100, 16'h1200);
      poke(12'h101, 16'h5201);
      poke(12'h102, 16'h2202);
      poke(12'h103, 16'h3203);
      poke(12'h104, 16'h0000);
      poke(12'h300, 16'h0000);
      poke(12'h002, 16'h0300);
      poke(12'h200, a);
      poke(12'h201, b);
      poke(12'h202, 16'hDEAD);
      poke(12'h203, 16'h0001);
      irq_type = 2'd2;
      irq_req  = 1'b1;
      run_prog(0);
      chk("R3 sum stored", mem[12'h202], a + b);
      chk("R4 R5 R11 saved flags", mem[12'hFFF], exp_psw(a, b));
      chk("R7 saved pc", mem[12'hFFE], 16'h0104);
      chk("R7 one ack", 16'(ack_cnt), 16'd1);
    end

    // reset state, no-op opcode, enable and interrupt
    begin_test();
    repeat (3) @(negedge clk);
    chk("R1 we in reset", {15'd0, mem_we}, 16'h0);
    chk("R1 ack in reset", {15'd0, irq_ack}, 16'h0);
    chk("R1 halted cleared", {15'd0, halted}, 16'h0);
    poke(12'h100, 16'h2210);
    poke(12'h101, 16'h4210);
    poke(12'h102, 16'h3203);
    poke(12'h103, 16'h0000);
    poke(12'h320, 16'h0000);
    poke(12'h000, 16'h0320);
    poke(12'h210, 16'hDEAD);
    poke(12'h203, 16'h0001);
    irq_type = 2'd0;
    irq_req  = 1'b1;
    run_prog(0);
    chk("R1 accumulator zero", mem[12'h210], 16'h0000);
    chk("R1 R6 status zero", mem[12'hFFF], 16'h0001);
    chk("R2 R6 return address", mem[12'hFFE], 16'h0103);

    // pending request, return restores flags and enable
    begin_test();
    poke(12'h100, 16'h1200);
    poke(12'h101, 16'h3203);
    poke(12'h102, 16'h2205);
    poke(12'h103, 16'h3206);
    poke(12'h104, 16'h0000);
    poke(12'h300, 16'h5201);
    poke(12'h301, 16'h2204);
    poke(12'h302, 16'hF000);
    poke(12'h001, 16'h0300);
    poke(12'h200, 16'h0005);
    poke(12'h201, 16'hFFFB);
    poke(12'h203, 16'h0001);
    poke(12'h206, 16'h0000);
    poke(12'h204, 16'hDEAD);
    poke(12'h205, 16'hDEAD);
    irq_type = 2'd1;
    irq_req  = 1'b1;
    run_prog(1);
    chk("R8 two services", 16'(ack_cnt), 16'd2);
    chk("R9 R4 flags restored", mem[12'hFFF], 16'h0011);
    chk("R9 return address", mem[12'hFFE], 16'h0102);
    chk("R3 handler sum", mem[12'h204], 16'hFFFB);
    chk("R9 resumed main", mem[12'h205], 16'hFFFB);

    // nested entry from a handler that re-enables
    begin_test();
    poke(12'h100, 16'h3203);
    poke(12'h101, 16'h0000);
    poke(12'h340, 16'h3203);
    poke(12'h341, 16'h0000);
    poke(12'h003, 16'h0340);
    poke(12'h203, 16'h0001);
    irq_type = 2'd3;
    irq_req  = 1'b1;
    run_prog(2);
    chk("R7 outer status", mem[12'hFFF], 16'h0001);
    chk("R7 outer pc", mem[12'hFFE], 16'h0101);
    chk("R7 R11 supervisor saved", mem[12'hFFD], 16'h0003);
    chk("R7 inner pc", mem[12'hFFC], 16'h0341);

    // halted core ignores a request
    @(negedge clk);
    irq_req = 1'b1;
    repeat (30) @(negedge clk);
    chk("R10 no ack while halted", 16'(ack_cnt), 16'd2);
    chk("R10 no activity after halt", 16'(halt_we), 16'd0);
    chk("R10 halt sticky", {15'd0, halted}, 16'h0001);
    irq_req = 1'b0;

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule